// File: doc/BRIEF.md
# I2C Bus Master Line Sequencer

This block produces the clock (SCL) and data (SDA) line activity of a single I2C bus master at bit level. A controller above it hands over one primitive at a time: a START condition, a REPEATED START, a STOP condition, the transmission of one data bit, or the reception of one data bit. When the primitive is complete the block raises `done` for one cycle. After a receive it also presents the SDA level it sampled. Byte framing, acknowledge policy and message sequencing belong to the controller.

Both lines are open-drain. The block drives one pull-low enable per line and reads the SDA level back. Timing comes from two phase lengths, a low phase and a high phase, in system-clock cycles. Each is computed as `CLK_HZ * ns / 1e9 + 1`. Standard speed uses 4700 ns low and 4000 ns high. Fast speed uses 1300 ns low and 600 ns high. Start setup and bus-free intervals use the low length. Start hold and stop setup use the high length. The speed input is latched when a command is accepted.

Top module: `i2c_line_seq`

## Requirements
- R1: While reset is held and right after it, both pull-low enables are 0 (lines released), and `busy` and `done` are 0.
- R2: The low phase lasts `CLK_HZ*T/1e9+1` cycles with T = 4700 ns at standard speed (`speed_fast`=0) and 1300 ns at fast speed. The high phase uses T = 4000 ns and 600 ns respectively. With the default 50 MHz these are 236/201 and 66/31 cycles.
- R3: START (code 0) with SDA reading high at acceptance pulls SDA low for one high phase and leaves SCL as it was.
- R4: START with SDA reading low first pulls SCL low for one low phase, then releases SCL for one low phase, and only then pulls SDA low for one high phase. SCL stays released.
- R5: REPEATED START (code 1) leaves both lines unchanged for one low phase and then performs the START of R3/R4, judging SDA at the end of that wait.
- R6: STOP (code 2) with SDA reading high holds the lines for one low phase, then pulls SDA low for one high phase. It then keeps SDA for one high phase and releases SDA for one low phase.
- R7: STOP with SDA reading low skips the first two phases of R6. It waits one high phase, then releases SDA for one low phase.
- R8: WRITE BIT (code 3) pulls SCL low and sets the SDA enable to the inverse of `cmd_wbit` for one low phase. It then releases SCL for one high phase.
- R9: READ BIT (code 4) pulls SCL low and releases SDA for one low phase. It then releases SCL for one high phase. `rd_bit` shows the SDA level seen in the last cycle of the low phase, and it holds that value until the next read.
- R10: A command is accepted only when `cmd_valid` is 1, `busy` is 0 and the code is 0 to 4. Codes 5 to 7, and any command presented while busy, change neither the lines nor the sequence in progress.
- R11: `done` is a single-cycle pulse in the cycle after the last phase ends, with `busy` already 0. The speed used for a whole command is the value of `speed_fast` at acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 3 | 0 START, 1 REPEATED START, 2 STOP, 3 WRITE BIT, 4 READ BIT |
| cmd_wbit | input | 1 | Bit value for WRITE BIT |
| speed_fast | input | 1 | 0 standard, 1 fast; latched at acceptance |
| sda_in | input | 1 | SDA line level read back |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | SDA level sampled by the last READ BIT |

## Verification
The bench sweeps every command at both speeds and compares each cycle against a phase list built arithmetically from the nanosecond values. A wrong length formula or a swapped low/high alias therefore shows up as a segment that ends early or late. Both branches of START and STOP are driven by holding SDA low from a simulated slave or from the master itself. A design that ignored the read-back would skip the recovery pulse or the forced low, or add them where they do not belong. A command and a flipped speed are injected mid-command, and a reserved code is applied while idle; a design without the idle gate or the speed latch would bend the waveform it is producing. Reads against both slave levels catch a sample taken at the wrong point or a bit that is inverted.

// File: rtl/i2c_line_seq_pkg.sv
package i2c_line_seq_pkg;

  typedef enum logic [2:0] {
    CMD_START  = 3'd0,
    CMD_RSTART = 3'd1,
    CMD_STOP   = 3'd2,
    CMD_WBIT   = 3'd3,
    CMD_RBIT   = 3'd4
  } cmd_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_RCV_LO,
    PH_RCV_HI,
    PH_ST_HOLD,
    PH_RS_WAIT,
    PH_SP_PRE,
    PH_SP_LOW,
    PH_SP_SETUP,
    PH_SP_FREE,
    PH_WB_LO,
    PH_WB_HI,
    PH_RB_LO,
    PH_RB_HI
  } phase_e;

  localparam logic [2:0] CMD_LAST = 3'd4;

  // cycles = hz * ns / 1e9 + 1
  function automatic longint unsigned ns_to_cycles(input longint unsigned hz,
                                                   input longint unsigned ns);
    return (hz * ns) / 64'd1_000_000_000 + 64'd1;
  endfunction

endpackage

// File: rtl/i2c_phase_len.sv
module i2c_phase_len #(
  parameter longint unsigned CLK_HZ = 50_000_000,
  parameter int unsigned     CNT_W  = 32
) (
  input  logic             fast,
  input  logic             use_high,
  output logic [CNT_W-1:0] len
);
  import i2c_line_seq_pkg::*;

  localparam int unsigned NS_LO_STD  = 4700;
  localparam int unsigned NS_HI_STD  = 4000;
  localparam int unsigned NS_LO_FAST = 1300;
  localparam int unsigned NS_HI_FAST = 600;

  logic [CNT_W-1:0] table_q [4];

  // index = {fast, use_high}
  for (genvar g = 0; g < 4; g++) begin : g_len
    localparam int unsigned NS = (g == 0) ? NS_LO_STD  :
                                 (g == 1) ? NS_HI_STD  :
                                 (g == 2) ? NS_LO_FAST : NS_HI_FAST;
    localparam longint unsigned CYC = ns_to_cycles(CLK_HZ, longint'(NS));
    assign table_q[g] = CYC[CNT_W-1:0];
  end

  assign len = table_q[{fast, use_high}];

endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = (cnt == CNT_W'(1));

  // R2: a loaded phase never has zero length
  p_load_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));

endmodule

// File: rtl/i2c_phase_fsm.sv
module i2c_phase_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       cmd_wbit,
  input  logic       sda_in,
  input  logic       expire,
  output logic       accept,
  output logic       load,
  output logic       use_high,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       done,
  output logic       rd_bit
);
  import i2c_line_seq_pkg::*;

  phase_e state, nxt;
  logic   advance;

  assign busy    = (state != PH_IDLE);
  assign accept  = cmd_valid && !busy && (cmd_code <= CMD_LAST);
  assign advance = accept || (busy && expire);

  always_comb begin
    nxt = state;
    if (accept) begin
      unique case (cmd_e'(cmd_code))
        CMD_START:  nxt = sda_in ? PH_ST_HOLD : PH_RCV_LO;
        CMD_RSTART: nxt = PH_RS_WAIT;
        CMD_STOP:   nxt = sda_in ? PH_SP_PRE : PH_SP_SETUP;
        CMD_WBIT:   nxt = PH_WB_LO;
        default:    nxt = PH_RB_LO;
      endcase
    end else if (busy && expire) begin
      unique case (state)
        PH_RCV_LO:   nxt = PH_RCV_HI;
        PH_RCV_HI:   nxt = PH_ST_HOLD;
        PH_RS_WAIT:  nxt = sda_in ? PH_ST_HOLD : PH_RCV_LO;
        PH_SP_PRE:   nxt = PH_SP_LOW;
        PH_SP_LOW:   nxt = PH_SP_SETUP;
        PH_SP_SETUP: nxt = PH_SP_FREE;
        PH_WB_LO:    nxt = PH_WB_HI;
        PH_RB_LO:    nxt = PH_RB_HI;
        default:     nxt = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (nxt)
      PH_ST_HOLD, PH_SP_LOW, PH_SP_SETUP, PH_WB_HI, PH_RB_HI: use_high = 1'b1;
      default:                                                use_high = 1'b0;
    endcase
  end

  assign load = advance && (nxt != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PH_IDLE;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      rd_bit <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == PH_RB_LO && expire) begin
        rd_bit <= sda_in;
      end
      if (advance) begin
        state <= nxt;
        unique case (nxt)
          PH_RCV_LO:  scl_oe <= 1'b1;
          PH_RCV_HI:  scl_oe <= 1'b0;
          PH_ST_HOLD: sda_oe <= 1'b1;
          PH_SP_LOW:  sda_oe <= 1'b1;
          PH_SP_FREE: sda_oe <= 1'b0;
          PH_WB_LO: begin
            scl_oe <= 1'b1;
            sda_oe <= ~cmd_wbit;
          end
          PH_WB_HI:   scl_oe <= 1'b0;
          PH_RB_LO: begin
            scl_oe <= 1'b1;
            sda_oe <= 1'b0;
          end
          PH_RB_HI:   scl_oe <= 1'b0;
          PH_IDLE:    done   <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  p_wr_low_phase_r8: assert property (@(posedge clk) disable iff (rst)
    (state == PH_WB_LO) |-> scl_oe);
  p_rd_low_phase_r9: assert property (@(posedge clk) disable iff (rst)
    (state == PH_RB_LO) |-> (scl_oe && !sda_oe));
  p_start_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state == PH_ST_HOLD) |-> sda_oe);
  p_recovery_r4: assert property (@(posedge clk) disable iff (rst)
    (state == PH_RCV_LO) |-> scl_oe);
  p_bus_free_r6: assert property (@(posedge clk) disable iff (rst)
    (state == PH_SP_FREE) |-> !sda_oe);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: rtl/i2c_line_seq.sv
module i2c_line_seq #(
  parameter longint unsigned CLK_HZ = 50_000_000,
  parameter int unsigned     CNT_W  = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       cmd_wbit,
  input  logic       speed_fast,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       done,
  output logic       rd_bit
);
  logic             accept, load, use_high, expire, mode_q, mode_eff;
  logic [CNT_W-1:0] len;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
    end else if (accept) begin
      mode_q <= speed_fast;
    end
  end

  assign mode_eff = accept ? speed_fast : mode_q;

  i2c_phase_len #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) i_len (
    .fast     (mode_eff),
    .use_high (use_high),
    .len      (len)
  );

  i2c_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (len),
    .expire   (expire)
  );

  i2c_phase_fsm i_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_wbit  (cmd_wbit),
    .sda_in    (sda_in),
    .expire    (expire),
    .accept    (accept),
    .load      (load),
    .use_high  (use_high),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .done      (done),
    .rd_bit    (rd_bit)
  );

  // R11: speed stays fixed for the whole command
  p_mode_locked_r11: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mode_q));
  // R10: timer only expires inside a command
  p_expire_busy_r10: assert property (@(posedge clk) disable iff (rst)
    expire |-> busy);

endmodule

// File: tb/test_i2c_line_seq.sv
module test_i2c_line_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic cmd_wbit = 1'b0;
  logic speed_fast = 1'b0;
  logic pull = 1'b0;
  logic sda_in, scl_oe, sda_oe, busy, done, rd_bit;

  int errors = 0;
  int checks = 0;

  assign sda_in = !(sda_oe || pull);

  always #10 clk = ~clk;  // 50 MHz

  i2c_line_seq i_i2c_line_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_wbit(cmd_wbit), .speed_fast(speed_fast), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .rd_bit(rd_bit)
  );

  localparam longint HZ = 50_000_000;
  int lo_c, hi_c;

  bit q_scl [16];
  bit q_sda [16];
  int q_len [16];
  int nq;
  bit m_scl, m_sda;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_speed(input bit f);
    lo_c = int'(HZ * (f ? 1300 : 4700) / 1_000_000_000 + 1);
    hi_c = int'(HZ * (f ? 600 : 4000) / 1_000_000_000 + 1);
  endtask

  task automatic seg(input bit s, input bit d, input int n);
    q_scl[nq] = s; q_sda[nq] = d; q_len[nq] = n; nq++;
    m_scl = s; m_sda = d;
  endtask

  task automatic exp_start();
    if (m_sda || pull) begin
      seg(1'b1, m_sda, lo_c);
      seg(1'b0, m_sda, lo_c);
    end
    seg(m_scl, 1'b1, hi_c);
  endtask

  task automatic exp_stop();
    if (!(m_sda || pull)) begin
      seg(m_scl, m_sda, lo_c);
      seg(m_scl, 1'b1, hi_c);
    end
    seg(m_scl, m_sda, hi_c);
    seg(m_scl, 1'b0, lo_c);
  endtask

  // Runs one command and compares each cycle with the queued segments.
  task automatic run(input logic [2:0] code, input bit wb, input bit f,
                     input bit inject, input bit chk_rd, input bit exp_rd,
                     input string req);
    int k;
    cmd_valid = 1'b1; cmd_code = code; cmd_wbit = wb; speed_fast = f;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    k = 0;
    for (int s = 0; s < nq; s++) begin
      bit bad = 1'b0;
      int a_l = 0;
      int e_l = 0;
      for (int c = 0; c < q_len[s]; c++) begin
        if (!bad && (scl_oe !== q_scl[s] || sda_oe !== q_sda[s] || done !== 1'b0
                     || busy !== 1'b1)) begin
          bad = 1'b1;
          a_l = {busy, done, scl_oe, sda_oe};
          e_l = {1'b1, 1'b0, q_scl[s], q_sda[s]};
          $display("  segment %0d cycle %0d mismatch", s, c);
        end
        if (inject && k == 2) begin
          cmd_valid = 1'b1; cmd_code = 3'd4; speed_fast = !f;
        end else begin
          cmd_valid = 1'b0;
        end
        k++;
        @(negedge clk);
      end
      check(!bad, req, "segment {busy,done,scl_oe,sda_oe}", a_l, e_l);
    end
    check(done === 1'b1 && busy === 1'b0, "R11", "done pulse at end",
          {busy, done}, 2'b01);
    if (chk_rd) check(rd_bit === exp_rd, "R9", "rd_bit", rd_bit, exp_rd);
    @(negedge clk);
    check(done === 1'b0, "R11", "done single cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(scl_oe === 1'b0 && sda_oe === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R1", "reset state", {scl_oe, sda_oe, busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(scl_oe === 1'b0 && sda_oe === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R1", "after reset", {scl_oe, sda_oe, busy, done}, 0);
    m_scl = 1'b0; m_sda = 1'b0;

    for (int f = 0; f < 2; f++) begin
      set_speed(f[0]);
      check(lo_c == (f ? 66 : 236) && hi_c == (f ? 31 : 201), "R2",
            "phase lengths", lo_c * 1000 + hi_c, f ? 66031 : 236201);
      // R6: STOP with SDA high
      pull = 0; nq = 0; exp_stop();   run(3'd2, 0, f[0], 0, 0, 0, "R6");
      // R3: START with SDA high
      nq = 0; exp_start();            run(3'd0, 0, f[0], 0, 0, 0, "R3");
      // R8: write 1 and write 0
      nq = 0; seg(1, 0, lo_c); seg(0, 0, hi_c); run(3'd3, 1, f[0], 0, 0, 0, "R8");
      nq = 0; seg(1, 1, lo_c); seg(0, 1, hi_c); run(3'd3, 0, f[0], 0, 0, 0, "R8");
      // R7: STOP with SDA low
      nq = 0; exp_stop();             run(3'd2, 0, f[0], 0, 0, 0, "R7");
      // R4: START with slave holding SDA low
      pull = 1; nq = 0; exp_start();  run(3'd0, 0, f[0], 0, 0, 0, "R4");
      pull = 0;
      // R9: reads of both slave levels
      nq = 0; seg(1, 0, lo_c); seg(0, 0, hi_c); run(3'd4, 0, f[0], 0, 1, 1, "R9");
      pull = 1;
      nq = 0; seg(1, 0, lo_c); seg(0, 0, hi_c); run(3'd4, 0, f[0], 0, 1, 0, "R9");
      pull = 0;
      // R5: repeated start, SDA high
      nq = 0; seg(m_scl, m_sda, lo_c); exp_start(); run(3'd1, 0, f[0], 0, 0, 0, "R5");
      // R10 and R11: command and flipped speed injected while busy
      nq = 0; seg(1, 1, lo_c); seg(0, 1, hi_c); run(3'd3, 0, f[0], 1, 0, 0, "R10");
      // R5 with R4 recovery path
      pull = 1;
      nq = 0; seg(m_scl, m_sda, lo_c); exp_start(); run(3'd1, 0, f[0], 0, 0, 0, "R5");
      pull = 0;
      // R10: reserved code while idle is ignored
      cmd_valid = 1'b1; cmd_code = 3'd6;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && scl_oe === m_scl && sda_oe === m_sda, "R10",
            "reserved code ignored", {busy, scl_oe, sda_oe}, {1'b0, m_scl, m_sda});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule